// File: doc/BRIEF.md
# Boot Strap Sampler and Pin Configurator

This block fixes how a chip starts up. Two strap pins in a 32-pin general-purpose I/O bank are read once, when the active-low reset is released. Their two-bit value picks one of four boot modes. Three of the modes are coprocessor modes. In these, an external host drives the chip through one interface: a 16-bit parallel host port, a high-speed serial port, or an SPI slave. The fourth mode is standalone. In that mode the chip loads its own firmware from a serial EEPROM.

The strap pins stay reserved as inputs for a fixed boot window after reset release. When the window ends, the block raises a done flag. It then enables the chosen interface and frees the strap pins. In standalone mode it also gives several neighbouring pins to the EEPROM, a debug UART and the on-the-go ID input. The ID input sets whether the on-the-go port acts as host or peripheral.

The outputs are the latched mode, the mode flags, one enable per interface, per-pin direction and function-select vectors, per-port role bits and the done flag. The interface engines, the USB logic and the loader sit outside the block.

Top module: `boot_strap_ctrl`

## Requirements
- R1: Strap pins 31 (high bit) and 30 (low bit) pass through a two-flop synchronizer. The block latches them into `boot_mode` on the first rising clock edge after `rst_n` goes high. Any later change on those pins has no effect on `boot_mode` until the next reset.
- R2: `boot_mode` decodes as follows: 2'b00 is the parallel host port, 2'b01 the high-speed serial port, 2'b10 the SPI slave, and 2'b11 standalone EEPROM boot. `standalone` is 1 only for 2'b11.
- R3: `boot_done` goes high exactly `WIN_CYCLES` rising edges after the latching edge. It then stays high until reset.
- R4: Between the latching edge and `boot_done`, `pin_alt` is 1 on bits 31 and 30 only. In that interval `pin_oe` is all zero and `if_en` is zero. Once `boot_done` is high in a coprocessor mode, bits 31 and 30 of both `pin_alt` and `pin_oe` are 0, so the pins are general-purpose.
- R5: Once `boot_done` is high, `if_en` has exactly one bit set, at index `boot_mode`. Bit 0 is the parallel port, bit 1 the serial port, bit 2 the SPI slave and bit 3 the EEPROM.
- R6: In a coprocessor mode after `boot_done`, `pin_oe`, `pin_alt`, `uart_en` and `port_host` are all zero.
- R7: In standalone mode after `boot_done`, `pin_oe` is 1 on bits 31, 30 and 28 (EEPROM pair and UART transmit) and 0 elsewhere. `pin_alt` is 1 on bits 31 down to 27 and 0 elsewhere, and `uart_en` is 1.
- R8: In standalone mode after `boot_done`, `port_host[0]` is the inverse of GPIO pin 29 (ID 0 means host, ID 1 means peripheral). The output follows the pin two rising edges after it changes. `port_host[3:1]` is always 0.
- R9: While `rst_n` is low, without waiting for a clock edge, these outputs are all zero: `boot_mode`, `standalone`, `if_en`, `uart_en`, `boot_done`, `pin_oe`, `pin_alt` and `port_host`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | GPIO_W | Pin levels of the I/O bank (31/30 straps, 29 ID) |
| boot_mode | output | 2 | Latched strap code |
| standalone | output | 1 | Latched mode is standalone |
| if_en | output | 4 | One-hot interface enable: parallel, serial, SPI, EEPROM |
| uart_en | output | 1 | Debug UART on pins 28/27 enabled |
| boot_done | output | 1 | Boot window has expired |
| pin_oe | output | GPIO_W | Per-pin output enable (1 = output) |
| pin_alt | output | GPIO_W | Per-pin dedicated function (1 = not general-purpose) |
| port_host | output | 4 | Per-port role, 1 = host; bit 0 is the on-the-go port |

## Verification
The bench targets the following corner cases:

- **Strap changes during the boot window.** A design that sampled continuously would pick up the new value.
- **The exact edge on which `boot_done` rises.** An off-by-one counter would rise one edge early or one edge late.
- **ID pin toggles in standalone mode.** An inverted role, or a missing synchronizer stage, shows up here.
- **Reset asserted mid-run.** A synchronous reset would leave enables active until the next clock edge.

All four strap codes are covered directly. Random passes then mix straps, ID levels and mid-window disturbances.

// File: rtl/boot_strap_ctrl.sv
module boot_strap_ctrl #(
  parameter int GPIO_W     = 32,
  parameter int WIN_CYCLES = 750000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GPIO_W-1:0] gpio_in,
  output logic [1:0]        boot_mode,
  output logic              standalone,
  output logic [3:0]        if_en,
  output logic              uart_en,
  output logic              boot_done,
  output logic [GPIO_W-1:0] pin_oe,
  output logic [GPIO_W-1:0] pin_alt,
  output logic [3:0]        port_host
);
  localparam int CW   = $clog2(WIN_CYCLES + 1);
  localparam int P_HI = 31;
  localparam int P_LO = 30;
  localparam int P_ID = 29;
  localparam int P_TX = 28;
  localparam int P_RX = 27;
  localparam logic [1:0] M_SOLO = 2'b11;

  logic [2:0]    sync1, sync2;
  logic [1:0]    mode_q;
  logic          sampled, done_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    sync1 <= {gpio_in[P_HI], gpio_in[P_LO], gpio_in[P_ID]};
    sync2 <= sync1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      sampled <= 1'b0;
      done_q  <= 1'b0;
      cnt     <= '0;
    end else if (!sampled) begin
      mode_q  <= sync2[2:1];
      sampled <= 1'b1;
      cnt     <= '0;
    end else if (!done_q) begin
      if (cnt == CW'(WIN_CYCLES - 1)) done_q <= 1'b1;
      else                            cnt    <= cnt + 1'b1;
    end
  end

  assign boot_mode  = mode_q;
  assign boot_done  = done_q;
  assign standalone = sampled && (mode_q == M_SOLO);
  assign if_en      = done_q ? (4'b0001 << mode_q) : 4'b0000;
  assign uart_en    = done_q && standalone;
  assign port_host  = {3'b000, uart_en & ~sync2[0]};

  always_comb begin
    pin_oe  = '0;
    pin_alt = '0;
    if (sampled && !done_q) begin
      pin_alt[P_HI] = 1'b1;
      pin_alt[P_LO] = 1'b1;
    end
    if (uart_en) begin
      pin_oe[P_HI]  = 1'b1;
      pin_oe[P_LO]  = 1'b1;
      pin_oe[P_TX]  = 1'b1;
      pin_alt[P_HI] = 1'b1;
      pin_alt[P_LO] = 1'b1;
      pin_alt[P_ID] = 1'b1;
      pin_alt[P_TX] = 1'b1;
      pin_alt[P_RX] = 1'b1;
    end
  end
endmodule

// File: rtl/boot_strap_ctrl_chk.sv
module boot_strap_ctrl_chk #(
  parameter int GPIO_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        boot_mode,
  input logic              standalone,
  input logic [3:0]        if_en,
  input logic              uart_en,
  input logic              boot_done,
  input logic [GPIO_W-1:0] pin_oe,
  input logic [GPIO_W-1:0] pin_alt,
  input logic [3:0]        port_host
);
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> $stable(boot_mode)); // R1
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done); // R3
  AST_WINDOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |-> (pin_oe == '0 && if_en == 4'b0000)); // R4
  AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> ($countones(if_en) == 1 && if_en[boot_mode])); // R5
  AST_COPROC_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && !standalone) |-> (pin_oe == '0 && !uart_en && port_host == 4'b0000)); // R6
  AST_SOLO_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && standalone) |-> (pin_oe[31:30] == 2'b11 && pin_alt[31:27] == 5'b11111 && uart_en)); // R7
  AST_OTHER_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
    port_host[3:1] == 3'b000); // R8
  AST_RESET_SAFE: assert property (@(posedge clk)
    !rst_n |-> (if_en == 4'b0000 && pin_oe == '0 && pin_alt == '0 && !boot_done && !uart_en)); // R9
endmodule

bind boot_strap_ctrl boot_strap_ctrl_chk #(.GPIO_W(GPIO_W)) u_chk (.*);

// File: tb/tb_boot_strap_ctrl.sv
`timescale 1ns/1ps
module tb_boot_strap_ctrl;
  localparam int W   = 32;
  localparam int WIN = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] gpio_in = '0;
  logic [1:0]   boot_mode;
  logic         standalone, uart_en, boot_done;
  logic [3:0]   if_en, port_host;
  logic [W-1:0] pin_oe, pin_alt;

  int checks = 0;
  int errs   = 0;

  always #2 clk = ~clk;

  boot_strap_ctrl #(.GPIO_W(W), .WIN_CYCLES(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in),
    .boot_mode(boot_mode), .standalone(standalone), .if_en(if_en),
    .uart_en(uart_en), .boot_done(boot_done), .pin_oe(pin_oe),
    .pin_alt(pin_alt), .port_host(port_host)
  );

  function automatic logic [W-1:0] exp_oe(input logic [1:0] m);
    return (m == 2'b11) ? 32'hD000_0000 : 32'h0;
  endfunction
  function automatic logic [W-1:0] exp_alt(input logic [1:0] m);
    return (m == 2'b11) ? 32'hF800_0000 : 32'h0;
  endfunction
  function automatic logic [3:0] exp_en(input logic [1:0] m);
    return 4'b0001 << m;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_straps(input logic [1:0] m, input logic id);
    gpio_in[31:30] = m;
    gpio_in[29]    = id;
  endtask

  task automatic boot_run(input logic [1:0] m, input logic id, input bit disturb, input int id_flips);
    logic cur_id;
    @(negedge clk);
    rst_n = 1'b0;
    gpio_in = W'($urandom);
    set_straps(m, id);
    cur_id = id;
    #1;
    chk("R9 reset en/oe/alt/done", {if_en, pin_oe, pin_alt, boot_done}, '0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 latched mode", {62'd0, boot_mode}, {62'd0, m});
    chk("R2 standalone flag", {63'd0, standalone}, {63'd0, m == 2'b11});
    chk("R4 window alt", {32'd0, pin_alt}, {32'd0, 32'hC000_0000});
    if (disturb) gpio_in[31:30] = ~m;
    repeat (WIN - 1) @(negedge clk);
    chk("R3 done not early", {63'd0, boot_done}, 64'd0);
    chk("R4 window quiet", {28'd0, if_en, pin_oe}, 64'd0);
    @(negedge clk);
    chk("R3 done on time", {63'd0, boot_done}, 64'd1);
    chk("R1 mode kept", {62'd0, boot_mode}, {62'd0, m});
    chk("R5 if_en", {60'd0, if_en}, {60'd0, exp_en(m)});
    if (m != 2'b11) begin
      chk("R4/R6 coproc oe/alt", {pin_oe, pin_alt}, 64'd0);
      chk("R6 coproc uart/role", {59'd0, uart_en, port_host}, 64'd0);
    end else begin
      chk("R7 solo oe", {32'd0, pin_oe}, {32'd0, exp_oe(m)});
      chk("R7 solo alt", {32'd0, pin_alt}, {32'd0, exp_alt(m)});
      chk("R7 uart", {63'd0, uart_en}, 64'd1);
      chk("R8 role", {60'd0, port_host}, {60'd0, 3'b000, ~cur_id});
    end
    gpio_in[31:30] = ~m;
    for (int k = 0; k < id_flips; k++) begin
      logic nid;
      nid = 1'($urandom);
      gpio_in[29] = nid;
      @(negedge clk);
      if (m == 2'b11 && nid != cur_id)
        chk("R8 role latency", {60'd0, port_host}, {60'd0, 3'b000, ~cur_id});
      @(negedge clk);
      cur_id = nid;
      chk("R8 role follow", {60'd0, port_host}, {60'd0, 3'b000, (m == 2'b11) & ~cur_id});
    end
    chk("R1 no resample", {62'd0, boot_mode}, {62'd0, m});
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    chk("R9 async reset", {boot_mode, standalone, if_en, uart_en, boot_done, port_host}, 64'd0);
    chk("R9 async pins", {pin_oe, pin_alt}, 64'd0);
  endtask

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #1;
    chk("R9 reset at start", {if_en, pin_oe, pin_alt, boot_done}, '0);
    boot_run(2'b00, 1'b0, 1'b0, 2);
    boot_run(2'b01, 1'b1, 1'b1, 2);
    boot_run(2'b10, 1'b0, 1'b1, 2);
    boot_run(2'b11, 1'b1, 1'b1, 4);
    boot_run(2'b11, 1'b0, 1'b0, 4);
    for (int i = 0; i < 30; i++)
      boot_run(2'($urandom), 1'($urandom), 1'($urandom), 1 + int'($urandom % 5));
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule